// File: doc/BRIEF.md
# Watchdog Overflow Reset Generator

The block is an up-counting watchdog timer with a small register interface. Software enables it and picks one of two modes. In watchdog mode the counter must be reloaded before it wraps. If the counter wraps instead, the block drives an active-low overflow strobe of fixed length. When resets are enabled, it also drives an internal reset pulse of fixed length, tagged as a power-on or a manual reset. In interval mode a wrap gives only a one-cycle interval pulse.

The counter advances only on cycles where the prescaler enable input is high. The pulse timers run on every system clock cycle. An external reset pin request clears the whole block. It takes priority over a watchdog overflow in the same cycle, so that overflow leaves no flag and no pulse behind.

Top module: `wdt_ovf_rstgen`

## Requirements
- R1: After `rst_n` is deasserted, `cnt_o` and `ctrl_o` read 0x00, `ovf_n_o` is 1, and `int_rst_o`, `rst_is_por_o` and `ivl_irq_o` are 0.
- R2: The control byte uses these bits: bit0 is the mode (1 = watchdog, 0 = interval) and bit1 is the timer enable. While the enable is 1, the counter rises by one on each clock edge where `tick_i` is 1, and it wraps from 0xFF to 0x00. A write with `wr_sel_i`=1 loads `wr_data_i` into the counter and takes priority over a tick in the same cycle.
- R3: In interval mode with the timer enabled, a wrap gives a one-cycle `ivl_irq_o` pulse in the next cycle. It starts no overflow or reset pulse and leaves the flag (bit7) unchanged.
- R4: In watchdog mode with bit2 (reset enable) at 1, a wrap drives `ovf_n_o` low for 132 cycles and drives `int_rst_o` high for 518 cycles. Both pulses start in the cycle after the wrapping edge.
- R5: In watchdog mode with bit2 at 0, a wrap drives `ovf_n_o` low for 130 cycles, and `int_rst_o` stays 0.
- R6: While `int_rst_o` is 1, `rst_is_por_o` equals the value bit3 had at the overflow that started the pulse (1 = power-on reset, 0 = manual reset).
- R7: Bit7 of `ctrl_o` is set by a watchdog overflow and then stays set. A control write (`wr_sel_i`=0) with bit7 at 0 clears it; a control write with bit7 at 1 leaves it unchanged.
- R8: When `pin_rst_i` is 1, the next cycle shows a counter of 0, a control byte of 0x00 including the flag, and no active pulse. A wrap in the same cycle sets no flag and starts no pulse.
- R9: A watchdog overflow while a pulse is active neither restarts nor lengthens that pulse.
- R10: Clearing the timer enable forces the counter to 0x00 and holds it there, ignoring ticks and counter writes. A pulse already running still completes its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pin_rst_i | input | 1 | External reset pin request, sampled synchronously |
| tick_i | input | 1 | One-cycle prescaler enable for the counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = control byte, 1 = counter |
| wr_data_i | input | 8 | Write data |
| cnt_o | output | 8 | Current counter value |
| ctrl_o | output | 8 | Control byte readback: {flag, 3'b0, type, reset enable, timer enable, mode} |
| ovf_n_o | output | 1 | Active-low overflow strobe |
| int_rst_o | output | 1 | Internal reset pulse |
| rst_is_por_o | output | 1 | Reset type of the running internal reset (1 = power-on) |
| ivl_irq_o | output | 1 | One-cycle interval pulse on wrap in interval mode |

## Verification
The hardest cases to reach are those where a second event lands inside a pulse that is already running. One is a new overflow in the middle of the 130-cycle strobe. Another is disabling the timer partway through a strobe. A third is a pin reset in the exact cycle the counter wraps. The bench preloads the counter with 0xFF, so a single tick produces the wrap at a cycle it chooses. It then schedules the second event a fixed number of cycles later, or in the same cycle for the pin reset. A negedge monitor records the length of every strobe and reset pulse, so any restart, extension or truncation shows up as a wrong length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW = 8;

    localparam int B_MODE  = 0;
    localparam int B_EN    = 1;
    localparam int B_RSTEN = 2;
    localparam int B_TYPE  = 3;
    localparam int B_FLAG  = DW - 1;

    typedef struct packed {
        logic wd_mode;
        logic tmr_en;
        logic rst_en;
        logic rst_type;
        logic flag;
        logic por;
        logic ivl;
    } ctl_t;
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !en)
            cnt_d = '0;
        else if (ld)
            cnt_d = ld_val;
        else if (tick)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign wrap = en && !clr && !ld && tick && (cnt_q == MAXV);

    // R10
    off_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);

    // R2
    tick_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !ld && tick) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         active
);
    typedef struct packed {
        logic         act;
        logic [W-1:0] rem;
    } pls_t;

    pls_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (st_q.act) begin
            if (st_q.rem == '0) st_d.act = 1'b0;
            else                st_d.rem = st_q.rem - 1'b1;
        end else if (start) begin
            st_d.act = 1'b1;
            st_d.rem = len - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;

    // R4
    pulse_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_q.act && !clr) |=> st_q.act);

    // R9
    pulse_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !clr && st_q.rem != '0) |=> st_q.act && st_q.rem == $past(st_q.rem) - 1'b1);
endmodule

// File: rtl/wdt_ovf_rstgen.sv
module wdt_ovf_rstgen
    import wdt_pkg::*;
#(
    parameter int OVF_LEN_RST   = 132,
    parameter int OVF_LEN_NORST = 130,
    parameter int RST_LEN       = 518
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_rst_i,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic          wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] ctrl_o,
    output logic          ovf_n_o,
    output logic          int_rst_o,
    output logic          rst_is_por_o,
    output logic          ivl_irq_o
);
    localparam int MAXL = (RST_LEN > OVF_LEN_RST) ? RST_LEN : OVF_LEN_RST;
    localparam int PW   = $clog2(MAXL + 1);
    localparam logic [PW-1:0] L_OVF_R = PW'(OVF_LEN_RST);
    localparam logic [PW-1:0] L_OVF_N = PW'(OVF_LEN_NORST);
    localparam logic [PW-1:0] L_RST   = PW'(RST_LEN);

    ctl_t c_d, c_q;

    logic wrap, wd_ovf, ovf_act, rst_act, ctl_wr, cnt_wr;

    assign ctl_wr = wr_en_i && !wr_sel_i;
    assign cnt_wr = wr_en_i && wr_sel_i;
    assign wd_ovf = wrap && c_q.wd_mode && !pin_rst_i;

    always_comb begin
        c_d     = c_q;
        c_d.ivl = wrap && !c_q.wd_mode;
        if (ctl_wr) begin
            c_d.wd_mode  = wr_data_i[B_MODE];
            c_d.tmr_en   = wr_data_i[B_EN];
            c_d.rst_en   = wr_data_i[B_RSTEN];
            c_d.rst_type = wr_data_i[B_TYPE];
            c_d.flag     = c_q.flag && wr_data_i[B_FLAG];
        end
        if (wd_ovf) begin
            c_d.flag = 1'b1;
            if (c_q.rst_en && !rst_act)
                c_d.por = c_q.rst_type;
        end
        if (pin_rst_i)
            c_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    wdt_count #(.W(DW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pin_rst_i),
        .en     (c_q.tmr_en),
        .tick   (tick_i),
        .ld     (cnt_wr),
        .ld_val (wr_data_i),
        .cnt    (cnt_o),
        .wrap   (wrap)
    );

    wdt_pulse #(.W(PW)) u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pin_rst_i),
        .start  (wd_ovf),
        .len    (c_q.rst_en ? L_OVF_R : L_OVF_N),
        .active (ovf_act)
    );

    wdt_pulse #(.W(PW)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pin_rst_i),
        .start  (wd_ovf && c_q.rst_en),
        .len    (L_RST),
        .active (rst_act)
    );

    assign ovf_n_o      = !ovf_act;
    assign int_rst_o    = rst_act;
    assign rst_is_por_o = c_q.por;
    assign ivl_irq_o    = c_q.ivl;
    assign ctrl_o       = {c_q.flag, {(DW-5){1'b0}}, c_q.rst_type, c_q.rst_en,
                           c_q.tmr_en, c_q.wd_mode};

    // R8
    pin_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rst_i |=> !c_q.flag && ovf_n_o && !int_rst_o && cnt_o == '0);

    // R4
    rst_with_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_ovf && c_q.rst_en && !rst_act) |=> int_rst_o && !ovf_n_o);

    // R5
    no_rst_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_ovf && !c_q.rst_en && !rst_act) |=> !int_rst_o);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.flag && !pin_rst_i && !(ctl_wr && !wr_data_i[B_FLAG])) |=> c_q.flag);

    // R3
    ivl_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !c_q.wd_mode && !c_q.flag && !ctl_wr) |=> !c_q.flag && ivl_irq_o);
endmodule

// File: tb/wdt_ovf_rstgen_tb.sv
`timescale 1ns/1ps
module wdt_ovf_rstgen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_rst_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_sel_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] cnt_o, ctrl_o;
    logic       ovf_n_o, int_rst_o, rst_is_por_o, ivl_irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    wdt_ovf_rstgen u_dut (
        .clk(clk), .rst_n(rst_n), .pin_rst_i(pin_rst_i), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .cnt_o(cnt_o), .ctrl_o(ctrl_o), .ovf_n_o(ovf_n_o), .int_rst_o(int_rst_o),
        .rst_is_por_o(rst_is_por_o), .ivl_irq_o(ivl_irq_o)
    );

    // pulse-length monitor
    int cur_ovf = 0, last_ovf = 0, cur_rst = 0, last_rst = 0, irq_cnt = 0;
    logic por_hi = 1'b0, por_lo = 1'b0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!ovf_n_o) cur_ovf <= cur_ovf + 1;
        else if (cur_ovf != 0) begin last_ovf <= cur_ovf; cur_ovf <= 0; end
        if (int_rst_o) begin
            cur_rst <= cur_rst + 1;
            if (rst_is_por_o) por_hi <= 1'b1; else por_lo <= 1'b1;
        end else if (cur_rst != 0) begin last_rst <= cur_rst; cur_rst <= 0; end
        if (ivl_irq_o) irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic clr_mon();
        #1;
        last_ovf = 0; last_rst = 0; irq_cnt = 0; por_hi = 0; por_lo = 0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]  load;
        logic [7:0]  ticks;
        logic [7:0]  exp_cnt;
        logic [7:0]  exp_irq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h00, 8'd5,  8'h05, 8'd0},
        '{8'h10, 8'd3,  8'h13, 8'd0},
        '{8'hFE, 8'd3,  8'h01, 8'd1},
        '{8'hF0, 8'd16, 8'h00, 8'd1},
        '{8'h7F, 8'd1,  8'h80, 8'd0},
        '{8'hFF, 8'd2,  8'h01, 8'd1}
    };

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 cnt", cnt_o, 8'h00);
        chk("R1 ctrl", ctrl_o, 8'h00);
        chk("R1 ovf_n", ovf_n_o, 1);
        chk("R1 int_rst", int_rst_o, 0);
        chk("R1 irq", ivl_irq_o, 0);

        // R2 / R3: table in interval mode
        wr(1'b0, 8'h02);
        foreach (VECS[i]) begin
            clr_mon();
            wr(1'b1, VECS[i].load);
            for (int t = 0; t < int'(VECS[i].ticks); t++) tk();
            idle(1);
            chk("R2 table cnt", cnt_o, VECS[i].exp_cnt);
            chk("R3 table irq", irq_cnt, VECS[i].exp_irq);
            chk("R3 no strobe", last_ovf, 0);
            chk("R3 flag", ctrl_o[7], 0);
        end

        // R2 load beats tick
        @(negedge clk); wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 8'h40; tick_i = 1'b1;
        @(negedge clk); wr_en_i = 1'b0; tick_i = 1'b0;
        chk("R2 load priority", cnt_o, 8'h40);

        // R4 / R6 power-on type
        clr_mon();
        wr(1'b0, 8'h0F);
        wr(1'b1, 8'hFF);
        tk();
        chk("R4 strobe starts", ovf_n_o, 0);
        chk("R4 reset starts", int_rst_o, 1);
        idle(600);
        chk("R4 strobe len", last_ovf, 132);
        chk("R4 reset len", last_rst, 518);
        chk("R6 por seen", {por_hi, por_lo}, 2'b10);
        chk("R7 flag set", ctrl_o[7], 1);

        // R7 flag stickiness
        wr(1'b0, 8'h8F);
        chk("R7 keep", ctrl_o, 8'h8F);
        wr(1'b0, 8'h0F);
        chk("R7 clear", ctrl_o, 8'h0F);

        // R6 manual type
        clr_mon();
        wr(1'b0, 8'h07);
        wr(1'b1, 8'hFF);
        tk();
        idle(600);
        chk("R6 manual", {por_hi, por_lo}, 2'b01);
        chk("R6 reset len", last_rst, 518);

        // R5 no internal reset
        clr_mon();
        wr(1'b0, 8'h03);
        wr(1'b1, 8'hFF);
        tk();
        idle(10);
        chk("R5 no reset", int_rst_o, 0);
        idle(200);
        chk("R5 strobe len", last_ovf, 130);
        chk("R5 reset len", last_rst, 0);

        // R9 overflow inside pulse
        clr_mon();
        wr(1'b1, 8'hFF);
        tk();
        idle(20);
        wr(1'b1, 8'hFF);
        tk();
        idle(200);
        chk("R9 no restart", last_ovf, 130);

        // R10 disable mid-pulse
        clr_mon();
        wr(1'b1, 8'hFF);
        tk();
        idle(10);
        wr(1'b0, 8'h00);
        chk("R10 cnt zero", cnt_o, 0);
        tk(); tk(); tk();
        wr(1'b1, 8'h55);
        chk("R10 held", cnt_o, 0);
        idle(200);
        chk("R10 full len", last_ovf, 130);

        // R8 pin reset coincident with wrap
        clr_mon();
        wr(1'b0, 8'h0F);
        wr(1'b1, 8'hFF);
        @(negedge clk); tick_i = 1'b1; pin_rst_i = 1'b1;
        @(negedge clk); tick_i = 1'b0; pin_rst_i = 1'b0;
        chk("R8 ctrl", ctrl_o, 8'h00);
        chk("R8 ovf_n", ovf_n_o, 1);
        chk("R8 int_rst", int_rst_o, 0);
        chk("R8 cnt", cnt_o, 0);
        idle(5);
        chk("R8 stays idle", ovf_n_o, 1);

        // R8 pin reset during pulse clears flag
        wr(1'b0, 8'h0B);
        wr(1'b1, 8'hFF);
        tk();
        idle(5);
        @(negedge clk); pin_rst_i = 1'b1;
        @(negedge clk); pin_rst_i = 1'b0;
        chk("R8 flag cleared", ctrl_o[7], 0);
        chk("R8 pulse cut", {ovf_n_o, int_rst_o}, 2'b10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog got %0d exp %0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule